// File: doc/BRIEF.md
# Memory Bus Cycle Controller

This block is the processor-side master for single transfers to a slow memory. The core hands it one request at a time: an address, a direction bit and, for stores, a data word. The controller then runs a bus cycle on separate address, data and control lines. The address goes out first. An active-low strobe follows, one for reads and one for writes. The controller holds that strobe through wait states until memory reports ready. It then releases the strobe and pulses a completion flag to the core. For a read, the word returned by memory is handed back on that same completion cycle.

The cycle order is fixed: an address setup cycle, then a strobe cycle, then at least one wait cycle, then a release cycle. For a write, the data bus output-enable comes on together with the write strobe. It stays on through the release cycle, so memory still sees stable data when the strobe rises. Reads never enable the data driver.

Top module: `membus_cycle_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_rd_n` and `mem_wr_n` are 1, `mem_wdata_oe` is 0 and `rsp_done` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle `mem_addr` carries the request address and both strobes are still high (address setup).
- R3: For a read (`req_write` = 0), `mem_rd_n` is low from the second cycle after acceptance until the release cycle, and `mem_wr_n` stays high.
- R4: The strobe stays low for at least two cycles, one strobe cycle plus one wait cycle, even when `mem_ready` is already high.
- R5: `mem_ready` is ignored in the strobe cycle. It is sampled only in wait cycles, and the wait ends on the first rising edge where it is 1. So with memory needing L low-strobe cycles, the strobe stays low for max(2, L) cycles.
- R6: Read data is sampled from `mem_rdata` on the edge that ends the wait. It appears on `rsp_rdata` in the completion cycle and holds until the next read completes; writes leave it unchanged.
- R7: For a write (`req_write` = 1), `mem_wr_n` goes low and `mem_wdata_oe` goes high in the same cycle, with `mem_wdata` equal to the request data. Both stay in place through the release cycle. `mem_wdata_oe` is 0 at all other times, including every cycle of a read.
- R8: `req_ready` is 0 from the cycle after acceptance through the completion cycle. Request inputs that change or stay valid during that time have no effect on the bus. `req_ready` is 1 again in the cycle after completion.
- R9: `rsp_done` is a single-cycle pulse in the release cycle, and the active strobe is high in that cycle.
- R10: `mem_rd_n` and `mem_wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request is taken this edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last read word |
| mem_addr | output | AW | Address bus |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DW | Write data bus |
| mem_wdata_oe | output | 1 | Write data driver enable |
| mem_rdata | input | DW | Read data from memory |
| mem_ready | input | 1 | Memory has finished the access |

## Verification
The bench builds the controller with a 12-bit address and an 8-bit data word. With those widths the all-ones and all-zeros address and data values cost nothing to cover, and the bench's data pattern folds every address bit into the read word. The memory model puts a wrong word on the data bus whenever ready is low, so only a sample taken on the ready edge yields the right read data. Its latency is swept from "ready always high" up to several cycles, which covers both the minimum-wait floor and the stretched wait.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_FINISH
    } mbc_state_e;

    // Phases in which the selected strobe is held low.
    function automatic logic strobe_phase(input mbc_state_e st);
        return (st == ST_STROBE) || (st == ST_WAIT);
    endfunction

    // Phases in which write data is driven onto the bus.
    function automatic logic drive_phase(input mbc_state_e st);
        return (st == ST_STROBE) || (st == ST_WAIT) || (st == ST_FINISH);
    endfunction

endpackage

// File: rtl/mbc_sequencer.sv
module mbc_sequencer
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_ready,
    output mbc_state_e state
);

    mbc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: state_d = ST_WAIT;
            ST_WAIT:   if (mem_ready) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_SETUP));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !mem_ready) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/mbc_xfer_regs.sv
module mbc_xfer_regs #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_write,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_wdata,
    input  logic          capture,
    input  logic [DW-1:0] cap_data,
    output logic          write_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            write_q <= load_write;
            addr_q  <= load_addr;
            wdata_q <= load_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= cap_data;
    end

    // R6
    cap_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        capture |-> !write_q);

endmodule

// File: rtl/membus_cycle_ctrl.sv
module membus_cycle_ctrl
    import mbc_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdata_oe,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    mbc_state_e    st;
    logic          accept;
    logic          capture;
    logic          write_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (st == ST_WAIT) && mem_ready && !write_q;

    mbc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .mem_ready (mem_ready),
        .state     (st)
    );

    mbc_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_write (req_write),
        .load_addr  (req_addr),
        .load_wdata (req_wdata),
        .capture    (capture),
        .cap_data   (mem_rdata),
        .write_q    (write_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .rdata_q    (rdata_q)
    );

    assign mem_addr     = addr_q;
    assign mem_wdata    = wdata_q;
    assign mem_rd_n     = !(strobe_phase(st) && !write_q);
    assign mem_wr_n     = !(strobe_phase(st) && write_q);
    assign mem_wdata_oe = drive_phase(st) && write_q;
    assign rsp_done     = (st == ST_FINISH);
    assign rsp_rdata    = rdata_q;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> $stable(mem_addr));

    // R4
    min_low_rd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd_n) |=> !mem_rd_n);

    // R4
    min_low_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |=> !mem_wr_n);

    // R9
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_rd_n) || $rose(mem_wr_n)) |-> rsp_done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R7
    oe_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wdata_oe |-> mem_rd_n);

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

endmodule

// File: tb/membus_cycle_ctrl_test.sv
module membus_cycle_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, mem_rd_n, mem_wr_n, mem_wdata_oe;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;

    membus_cycle_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata),
        .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic          is_wr;
        logic [DW-1:0] rdata;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } exp_t;

    exp_t          sbq[$];
    int            checks = 0;
    int            fails = 0;
    int            lat = 0;
    int            lowcnt = 0;
    int            cyc = 0;
    logic [DW-1:0] last_rd = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return DW'(a) ^ DW'(a >> 4) ^ DW'(8'hA5);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model: ready after lat low-strobe cycles (lat 0 = always ready),
    // wrong data on the bus whenever ready is low.
    always @(negedge clk) begin
        if (!mem_rd_n || !mem_wr_n) lowcnt++;
        else lowcnt = 0;
        mem_ready = (lat == 0) || ((!mem_rd_n || !mem_wr_n) && lowcnt >= lat);
        mem_rdata = mem_ready ? pat(mem_addr) : ~pat(mem_addr);
    end

    always @(posedge clk) begin
        if (!mem_wr_n && mem_ready && mem_wdata_oe) begin
            wr_addr <= mem_addr;
            wr_data <= mem_wdata;
        end
    end

    // Monitor: scoreboard compare on each completion pulse
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(rsp_rdata == e.rdata, "R6 rdata", int'(rsp_rdata), int'(e.rdata));
                if (e.is_wr) begin
                    check(wr_addr == e.waddr, "R7 write addr", int'(wr_addr), int'(e.waddr));
                    check(wr_data == e.wdata, "R7 write data", int'(wr_data), int'(e.wdata));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(1'b0, "watchdog", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic xfer(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int l);
        exp_t e;
        int   lows;
        int   expl;
        bit   fin;
        lat = l;
        expl = (l > 2) ? l : 2;
        if (!w) last_rd = pat(a);
        e.is_wr = w; e.rdata = last_rd; e.waddr = a; e.wdata = d;
        sbq.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        // R8: scramble request inputs while busy
        req_addr = ~a; req_wdata = ~d; req_write = !w;
        check(!req_ready, "R8 busy", int'(req_ready), 0);
        check(mem_addr == a, "R2 addr", int'(mem_addr), int'(a));
        check(mem_rd_n && mem_wr_n, "R2 strobes high", int'({mem_rd_n, mem_wr_n}), 3);
        lows = 0;
        fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (rsp_done || lows > 100) begin
                fin = 1;
            end else begin
                lows++;
                if (w) begin
                    check(!mem_wr_n && mem_rd_n, "R7 write strobe", int'({mem_rd_n, mem_wr_n}), 2);
                    check(mem_wdata_oe && mem_wdata == d, "R7 data drive", int'(mem_wdata), int'(d));
                end else begin
                    check(!mem_rd_n && mem_wr_n, "R3 read strobe", int'({mem_rd_n, mem_wr_n}), 1);
                    check(!mem_wdata_oe, "R7 oe off in read", int'(mem_wdata_oe), 0);
                end
                check(mem_addr == a, "R8 addr held", int'(mem_addr), int'(a));
            end
        end
        req_valid = 1'b0;
        check(rsp_done, "R9 done seen", int'(rsp_done), 1);
        check(mem_rd_n && mem_wr_n, "R9 release", int'({mem_rd_n, mem_wr_n}), 3);
        check(lows == expl, (l <= 2) ? "R4 min wait" : "R5 wait length", lows, expl);
        check(!req_ready, "R8 busy at done", int'(req_ready), 0);
        if (w) check(mem_wdata_oe && mem_wdata == d, "R7 hold on release", int'(mem_wdata), int'(d));
        @(negedge clk);
        check(!rsp_done, "R9 single pulse", int'(rsp_done), 0);
        check(req_ready, "R8 ready again", int'(req_ready), 1);
        check(!mem_wdata_oe, "R7 oe off after", int'(mem_wdata_oe), 0);
        check(mem_rd_n && mem_wr_n, "R10 idle strobes", int'({mem_rd_n, mem_wr_n}), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && mem_rd_n && mem_wr_n && !mem_wdata_oe && !rsp_done,
              "R1 in reset", int'({req_ready, mem_rd_n, mem_wr_n, mem_wdata_oe, rsp_done}), 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && mem_rd_n && mem_wr_n && !mem_wdata_oe && !rsp_done,
              "R1 after reset", int'({req_ready, mem_rd_n, mem_wr_n, mem_wdata_oe, rsp_done}), 5'b11100);
        xfer(1'b0, 12'h123, 8'h00, 0);   // R4 ready always high
        xfer(1'b0, 12'hFFF, 8'h00, 1);   // R4
        xfer(1'b0, 12'h000, 8'h00, 2);   // R4
        xfer(1'b0, 12'h5A5, 8'h00, 3);   // R5
        xfer(1'b1, 12'h7E1, 8'hFF, 0);   // R7, R6 rdata unchanged
        xfer(1'b1, 12'hABC, 8'h3C, 4);   // R7, R5
        xfer(1'b0, 12'h800, 8'h00, 6);   // R5, R6
        xfer(1'b1, 12'h001, 8'h00, 2);   // R7
        xfer(1'b0, 12'h0F0, 8'h00, 0);   // R3
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R9 all completed", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule